// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in in a single combinational pass. The operands are split into four 4-bit slices. Each slice forms a generate and a propagate term for every bit position. It then forms all of its internal carries directly from those terms in sum-of-products form, so no carry ripples inside the slice. Each slice also reduces its bits to one slice-level propagate and one slice-level generate.

A second lookahead unit reads the four slice-level pairs and the carry-in, and it computes the carry entering every slice in the same expanded form. Nothing ripples from one slice to the next. The same unit also reduces the four slice pairs to a propagate and generate pair for the whole 16-bit block. Those two outputs let a wider adder treat this block as one group of a third lookahead level.

The per-bit propagate term is the inclusive OR of the two operand bits. The sum bit is still formed as the exclusive OR of both operand bits and the incoming carry.

Top module: `cla_two_level_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, treating both operands as unsigned.
- R2: `cout_o` equals bit 16 of the 17-bit unsigned result of `a_i + b_i + cin_i`.
- R3: `blk_p_o` is 1 exactly when every bit position has at least one operand bit set (`a_i[k] | b_i[k]` is 1 for every k from 0 to 15). Otherwise it is 0.
- R4: `blk_g_o` is 1 exactly when `a_i + b_i` without the carry-in reaches 2^16. Otherwise it is 0.
- R5: `cout_o` always equals `blk_g_o | (blk_p_o & cin_i)`. With `cin_i` = 0 it equals `blk_g_o`.
- R6: A carry entering at bit 0 reaches the carry-out through all four slices. All-ones plus a carry-in of 1 gives `sum_o` = 0x0000, `cout_o` = 1, `blk_p_o` = 1 and `blk_g_o` = 0. The carry entering each slice equals the carry out of the unsigned addition of all lower bits plus `cin_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum of operands and carry-in, modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 |
| blk_p_o | output | 1 | Block propagate for a further lookahead level |
| blk_g_o | output | 1 | Block generate for a further lookahead level |

## Verification
Block generate and block propagate can both be high for the same operands. This happens when every bit has a 1 and at least one bit has both operand bits set, for example all-ones plus all-ones. In that case the carry-out must come out as 1 whatever the carry-in is. The bench provokes this overlap directly with both carry-in values. It also provokes a propagate-only case, all-ones plus zero, where the carry-out has to follow the carry-in through all four slices. Each case is judged by comparing the sum, the carry-out and both block terms against a plain 17-bit addition and a per-bit scan computed in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned LA_MAX = 16;

  typedef logic [LA_MAX-1:0] la_vec_t;

  // AND of p[lo..hi]; an empty span (lo > hi) yields 1
  function automatic logic span_and(la_vec_t p, int lo, int hi);
    logic acc;
    acc = 1'b1;
    for (int k = 0; k < LA_MAX; k++) begin
      if (k >= lo && k <= hi) acc = acc & p[k];
    end
    return acc;
  endfunction

  // expanded carry into position idx: cin*p[0..idx-1] + sum_j g[j]*p[j+1..idx-1]
  function automatic logic sop_carry(la_vec_t g, la_vec_t p, logic cin, int idx);
    logic acc;
    acc = cin & span_and(p, 0, idx - 1);
    for (int j = 0; j < LA_MAX; j++) begin
      if (j < idx) acc = acc | (g[j] & span_and(p, j + 1, idx - 1));
    end
    return acc;
  endfunction

  // group generate over n positions: carry out with zero carry-in
  function automatic logic sop_group_gen(la_vec_t g, la_vec_t p, int n);
    return sop_carry(g, p, 1'b0, n);
  endfunction

  // group propagate over n positions
  function automatic logic sop_group_prop(la_vec_t p, int n);
    return span_and(p, 0, n - 1);
  endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic g_o,
  output logic p_o,
  output logic s_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i | b_i;
  assign s_o = a_i ^ b_i ^ c_i;
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-1:0] carry_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  la_vec_t g_ext;
  la_vec_t p_ext;

  assign g_ext = la_vec_t'(gen_i);
  assign p_ext = la_vec_t'(prop_i);

  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      carry_o[i] = sop_carry(g_ext, p_ext, cin_i, i);
    end
    grp_p_o = sop_group_prop(p_ext, int'(N));
    grp_g_o = sop_group_gen(g_ext, p_ext, int'(N));
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_c;

  for (genvar k = 0; k < W; k++) begin : g_cell
    cla_bit_cell cell_i (
      .a_i (a_i[k]),
      .b_i (b_i[k]),
      .c_i (bit_c[k]),
      .g_o (bit_g[k]),
      .p_o (bit_p[k]),
      .s_o (sum_o[k])
    );
  end

  cla_lookahead #(.N(W)) la_i (
    .gen_i   (bit_g),
    .prop_i  (bit_p),
    .cin_i   (cin_i),
    .carry_o (bit_c),
    .grp_p_o (grp_p_o),
    .grp_g_o (grp_g_o)
  );
endmodule

// File: rtl/cla_two_level_adder.sv
module cla_two_level_adder #(
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic [GROUP_W*NUM_GROUPS-1:0] a_i,
  input  logic [GROUP_W*NUM_GROUPS-1:0] b_i,
  input  logic                          cin_i,
  output logic [GROUP_W*NUM_GROUPS-1:0] sum_o,
  output logic                          cout_o,
  output logic                          blk_p_o,
  output logic                          blk_g_o
);
  localparam int unsigned WIDTH = GROUP_W * NUM_GROUPS;

  logic [NUM_GROUPS-1:0] grp_p;
  logic [NUM_GROUPS-1:0] grp_g;
  logic [NUM_GROUPS-1:0] grp_cin;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_slice
    cla_group #(.W(GROUP_W)) grp_i (
      .a_i     (a_i[k*GROUP_W +: GROUP_W]),
      .b_i     (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i   (grp_cin[k]),
      .sum_o   (sum_o[k*GROUP_W +: GROUP_W]),
      .grp_p_o (grp_p[k]),
      .grp_g_o (grp_g[k])
    );
  end

  cla_lookahead #(.N(NUM_GROUPS)) top_la_i (
    .gen_i   (grp_g),
    .prop_i  (grp_p),
    .cin_i   (cin_i),
    .carry_o (grp_cin),
    .grp_p_o (blk_p_o),
    .grp_g_o (blk_g_o)
  );

  assign cout_o = blk_g_o | (blk_p_o & cin_i);
endmodule

// File: rtl/cla_two_level_adder_chk.sv
module cla_two_level_adder_chk #(
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_GROUPS = 4
) (
  input logic [GROUP_W*NUM_GROUPS-1:0] a_i,
  input logic [GROUP_W*NUM_GROUPS-1:0] b_i,
  input logic                          cin_i,
  input logic [GROUP_W*NUM_GROUPS-1:0] sum_o,
  input logic                          cout_o,
  input logic                          blk_p_o,
  input logic                          blk_g_o,
  input logic [NUM_GROUPS-1:0]         grp_cin
);
  localparam int unsigned WIDTH = GROUP_W * NUM_GROUPS;

  logic [WIDTH:0] full_sum;
  logic [WIDTH:0] nocin_sum;
  logic [WIDTH:0] low_sum;
  logic [WIDTH-1:0] low_mask;

  always_comb begin
    full_sum  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    nocin_sum = {1'b0, a_i} + {1'b0, b_i};
    // R1
    sum_value_chk: assert (sum_o == full_sum[WIDTH-1:0]);
    // R2
    cout_value_chk: assert (cout_o == full_sum[WIDTH]);
    // R3
    blk_prop_chk: assert (blk_p_o == ((a_i | b_i) == {WIDTH{1'b1}}));
    // R4
    blk_gen_chk: assert (blk_g_o == nocin_sum[WIDTH]);
    // R5
    cout_relation_chk: assert (cout_o == (blk_g_o | (blk_p_o & cin_i)));
  end

  always_comb begin
    low_mask = '0;
    low_sum  = '0;
    for (int k = 1; k < int'(NUM_GROUPS); k++) begin
      low_mask = (WIDTH'(1) << (k * GROUP_W)) - WIDTH'(1);
      low_sum  = {1'b0, a_i & low_mask} + {1'b0, b_i & low_mask} + {{WIDTH{1'b0}}, cin_i};
      // R6
      slice_carry_chk: assert (grp_cin[k] == low_sum[k*GROUP_W]);
    end
    // R6
    slice0_carry_chk: assert (grp_cin[0] == cin_i);
  end
endmodule

bind cla_two_level_adder cla_two_level_adder_chk #(
  .GROUP_W    (GROUP_W),
  .NUM_GROUPS (NUM_GROUPS)
) chk_i (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .blk_p_o (blk_p_o),
  .blk_g_o (blk_g_o),
  .grp_cin (grp_cin)
);

// File: tb/cla_two_level_adder_tb_top.sv
`timescale 1ns/1ps
module cla_two_level_adder_tb_top;
  logic clk;
  logic [15:0] a;
  logic [15:0] b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;
  logic        blk_p;
  logic        blk_g;

  int n_checks;
  int n_fail;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  cla_two_level_adder dut_i (
    .a_i     (a),
    .b_i     (b),
    .cin_i   (cin),
    .sum_o   (sum),
    .cout_o  (cout),
    .blk_p_o (blk_p),
    .blk_g_o (blk_g)
  );

  function automatic logic [16:0] ref_add(logic [15:0] x, logic [15:0] y, logic c);
    logic [16:0] r;
    logic carry;
    carry = c;
    for (int k = 0; k < 16; k++) begin
      r[k]  = x[k] ^ y[k] ^ carry;
      carry = (x[k] & y[k]) | (carry & (x[k] ^ y[k]));
    end
    r[16] = carry;
    return r;
  endfunction

  function automatic logic ref_prop(logic [15:0] x, logic [15:0] y);
    logic all;
    all = 1'b1;
    for (int k = 0; k < 16; k++) if (!(x[k] || y[k])) all = 1'b0;
    return all;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s a=%h b=%h cin=%0b actual=%h expected=%h", req, what, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] x, logic [15:0] y, logic c);
    logic [16:0] e;
    logic [16:0] eg;
    @(negedge clk);
    a = x; b = y; cin = c;
    #2;
    e  = ref_add(x, y, c);
    eg = ref_add(x, y, 1'b0);
    check("R1", "sum", sum, e[15:0]);
    check("R2", "cout", {15'd0, cout}, {15'd0, e[16]});
    check("R3", "blk_p", {15'd0, blk_p}, {15'd0, ref_prop(x, y)});
    check("R4", "blk_g", {15'd0, blk_g}, {15'd0, eg[16]});
    check("R5", "cout_vs_pg", {15'd0, cout}, {15'd0, eg[16] | (ref_prop(x, y) & c)});
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    a = '0; b = '0; cin = 1'b0;
    void'($urandom(32'd20231));
    // zero inputs
    apply(16'h0000, 16'h0000, 1'b0);
    // R6: all-ones plus carry-in ripples through all four slices
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R6", "ones_plus_one_sum", sum, 16'h0000);
    check("R6", "ones_plus_one_cout", {15'd0, cout}, 16'd1);
    check("R6", "ones_plus_one_p", {15'd0, blk_p}, 16'd1);
    check("R6", "ones_plus_one_g", {15'd0, blk_g}, 16'd0);
    apply(16'hFFFF, 16'h0001, 1'b0);
    apply(16'hFFFF, 16'h0000, 1'b0);
    // block generate and propagate both high
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    // carries across each slice boundary
    apply(16'h000F, 16'h0001, 1'b0);
    apply(16'h00FF, 16'h0001, 1'b0);
    apply(16'h0FFF, 16'h0000, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'h5555, 16'hAAAA, 1'b1);
    apply(16'h5555, 16'hAAAA, 1'b0);
    apply(16'h0F0F, 16'hF0F0, 1'b1);
    for (int i = 0; i < 400; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    end
    // propagate-heavy random: b fills the gaps of a
    for (int i = 0; i < 100; i++) begin
      logic [15:0] x;
      x = 16'($urandom);
      apply(x, ~x | 16'($urandom & 32'h0000_0101), 1'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule